// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the 32-bit memory-mapped register layer of a byte-oriented serial port. A bus master reads and writes word registers through a simple slave port with separate read and write strobes. Bytes written to the transmit data register leave the block on a valid/ready byte stream, and bytes arriving on a second valid/ready byte stream are captured into a status word that the master polls. Bit-level framing, baud timing and buffering live elsewhere: exactly one received byte is held at a time.

Interrupts are collected in a raw register, gated by a mask register and reported on one level output. They are cleared by writing ones to a self-clearing acknowledge register. The transmit interrupt has one twist: acknowledging it while a transmit is still marked pending consumes the pending mark but leaves the interrupt raised, so a second acknowledge is needed to drop it. Status may be read through a consuming address, which clears the data-available flag, or through a peek address that changes nothing.

Back-pressure rules: the transmit stream holds `tx_valid` and `tx_data` steady until `tx_ready` is seen. A transmit data write that arrives while a byte is still held raises `bus_wait` and takes effect only in a cycle where `bus_wait` is low. On the receive side, `rx_ready` reflects the accept rule and a byte is taken in any cycle where `rx_valid` and `rx_ready` are both high.

Top module: `ser_regfile`

## Requirements
- R1: After reset every readable register reads zero except the status word (offsets 0x20 and 0x24), which reads 0x0140_0000 (transmitter-idle bit 22 and transmitter-ready bit 24 set); `irq` and `tx_valid` are low.
- R2: The transmit control (0x00), transmit DMA enable (0x04), receive control (0x08) and interrupt mask (0x2C) registers read back the full 32-bit value last written.
- R3: A write to offset 0x1C puts `bus_wdata[7:0]` on `tx_data` with `tx_valid` high from the next cycle; both stay steady until `tx_ready` is high, and status bits 22 and 24 read zero while a byte is held.
- R4: A write to 0x1C while a byte is held and `tx_ready` is low raises `bus_wait`; the write takes effect in the cycle the held byte is accepted, and bytes leave in write order.
- R5: A write to 0x1C sets raw interrupt bit 0 (offset 0x34) and marks a transmit as pending.
- R6: `rx_ready` is high when receive-control bit 0 is set or raw interrupt bit 3 is clear; an offered byte is otherwise not taken and the status word is unchanged.
- R7: A taken byte replaces status bits 7:0, sets data-available (status bit 16) and sets raw interrupt bit 3.
- R8: A read at 0x20 returns the status word and clears bit 16 afterwards unless a byte is taken in the same cycle; a read at 0x24 returns the same word and changes nothing.
- R9: A write to the acknowledge register (0x30) clears every raw bit set in the written value; 0x30 always reads zero.
- R10: An acknowledge with bit 0 set while a transmit is pending leaves raw bit 0 set and clears the pending mark; a later acknowledge of bit 0 then clears it.
- R11: Offset 0x38 reads raw AND mask, and `irq` is high exactly when that value is nonzero.
- R12: Reads of unmapped offsets (including 0x1C) return zero; writes to unmapped or read-only offsets (0x20, 0x24, 0x34, 0x38 and others) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the cycle `bus_rd` is high |
| bus_wait | output | 1 | Holds off a transmit data write while a byte is held |
| tx_valid | output | 1 | Transmit byte valid |
| tx_ready | input | 1 | Transmit byte accepted by the sink |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte offered |
| rx_ready | output | 1 | Block will take an offered byte |
| rx_data | input | 8 | Received byte |
| irq | output | 1 | Level interrupt, high while any masked interrupt is set |

## Verification
The assertions assume that the master never raises `bus_rd` and `bus_wr` in the same cycle and keeps a stalled write's address and data steady while `bus_wait` is high, and that the byte sink does not withdraw `tx_ready` mid-cycle. The bench drives every strobe and stream input just after the falling edge and holds it for one full cycle, issues at most one bus operation per cycle, and repeats a stalled write until it is let through. Sweeps walk all word offsets in the window, every combination of the two raw interrupt sources against every low mask nibble, and every low acknowledge nibble.

// File: rtl/ser_pkg.sv
package ser_pkg;
  localparam int DEC_W = 12;

  localparam logic [DEC_W-1:0] A_TXCTL   = 12'h000;
  localparam logic [DEC_W-1:0] A_DMAEN   = 12'h004;
  localparam logic [DEC_W-1:0] A_RXCTL   = 12'h008;
  localparam logic [DEC_W-1:0] A_DOUT    = 12'h01C;
  localparam logic [DEC_W-1:0] A_STATCLR = 12'h020;
  localparam logic [DEC_W-1:0] A_STAT    = 12'h024;
  localparam logic [DEC_W-1:0] A_MASK    = 12'h02C;
  localparam logic [DEC_W-1:0] A_ACK     = 12'h030;
  localparam logic [DEC_W-1:0] A_RAW     = 12'h034;
  localparam logic [DEC_W-1:0] A_MASKED  = 12'h038;

  localparam int B_DAV  = 16;
  localparam int B_IDLE = 22;
  localparam int B_RDY  = 24;
  localparam int I_TX   = 0;
  localparam int I_RX   = 3;

  typedef enum logic [3:0] {
    S_NONE, S_TXCTL, S_DMAEN, S_RXCTL, S_DOUT, S_STATCLR,
    S_STAT, S_MASK, S_ACK, S_RAW, S_MASKED
  } sel_e;

  function automatic sel_e decode(input logic [DEC_W-1:0] a);
    case (a)
      A_TXCTL:   return S_TXCTL;
      A_DMAEN:   return S_DMAEN;
      A_RXCTL:   return S_RXCTL;
      A_DOUT:    return S_DOUT;
      A_STATCLR: return S_STATCLR;
      A_STAT:    return S_STAT;
      A_MASK:    return S_MASK;
      A_ACK:     return S_ACK;
      A_RAW:     return S_RAW;
      A_MASKED:  return S_MASKED;
      default:   return S_NONE;
    endcase
  endfunction
endpackage

// File: rtl/ser_tx_hold.sv
module ser_tx_hold #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [BYTE_W-1:0] load_byte,
  input  logic              tx_ready,
  output logic              tx_valid,
  output logic [BYTE_W-1:0] tx_data,
  output logic              busy
);
  assign busy = tx_valid && !tx_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_valid <= 1'b0;
      tx_data  <= '0;
    end else if (load) begin
      tx_valid <= 1'b1;
      tx_data  <= load_byte;
    end else if (tx_valid && tx_ready) begin
      tx_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_rx_capture.sv
module ser_rx_capture #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              allow,
  input  logic              rx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              consume,
  output logic              rx_ready,
  output logic              take,
  output logic [BYTE_W-1:0] byte_q,
  output logic              dav_q
);
  assign rx_ready = allow;
  assign take     = rx_valid && allow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_q <= '0;
      dav_q  <= 1'b0;
    end else if (take) begin
      byte_q <= rx_data;
      dav_q  <= 1'b1;
    end else if (consume) begin
      dav_q  <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_irq_ctrl.sv
module ser_irq_ctrl #(
  parameter int DATA_W = 32,
  parameter int TX_BIT = 0,
  parameter int RX_BIT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_we,
  input  logic              ack_we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              tx_set,
  input  logic              rx_set,
  output logic [DATA_W-1:0] raw_q,
  output logic [DATA_W-1:0] mask_q,
  output logic [DATA_W-1:0] masked,
  output logic              tx_pend_q,
  output logic              irq
);
  logic              swallow;
  logic [DATA_W-1:0] ack_eff;
  logic [DATA_W-1:0] raw_n;

  assign swallow = ack_we && tx_pend_q && wdata[TX_BIT];

  always_comb begin
    ack_eff = wdata;
    if (swallow) ack_eff[TX_BIT] = 1'b0;
    raw_n = raw_q;
    if (ack_we) raw_n = raw_n & ~ack_eff;
    if (tx_set) raw_n[TX_BIT] = 1'b1;
    if (rx_set) raw_n[RX_BIT] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q     <= '0;
      mask_q    <= '0;
      tx_pend_q <= 1'b0;
    end else begin
      raw_q <= raw_n;
      if (mask_we) mask_q <= wdata;
      if (tx_set) tx_pend_q <= 1'b1;
      else if (swallow) tx_pend_q <= 1'b0;
    end
  end

  assign masked = raw_q & mask_q;
  assign irq    = |masked;
endmodule

// File: rtl/ser_regfile.sv
module ser_regfile
  import ser_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DEC_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_wait,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [BYTE_W-1:0] tx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  input  logic [BYTE_W-1:0] rx_data,
  output logic              irq
);
  localparam int N_CTRL = 3;

  sel_e              sel;
  logic              sel_dout, sel_ack, sel_peek;
  logic              wr_go, dout_go, tx_busy, rx_take;
  logic [DATA_W-1:0] ctrl_q [N_CTRL];
  logic [DATA_W-1:0] raw_q, mask_q, masked, stat;
  logic              tx_pend;
  logic [BYTE_W-1:0] rx_byte;
  logic              rx_dav;

  assign sel      = decode(bus_addr);
  assign sel_dout = (sel == S_DOUT);
  assign sel_ack  = (sel == S_ACK);
  assign sel_peek = (sel == S_STAT);
  assign bus_wait = bus_wr && sel_dout && tx_busy;
  assign wr_go    = bus_wr && !bus_wait;
  assign dout_go  = wr_go && sel_dout;

  function automatic sel_e ctrl_sel(input int i);
    case (i)
      0:       return S_TXCTL;
      1:       return S_DMAEN;
      default: return S_RXCTL;
    endcase
  endfunction

  for (genvar g = 0; g < N_CTRL; g++) begin : g_ctrl
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ctrl_q[g] <= '0;
      else if (wr_go && sel == ctrl_sel(g)) ctrl_q[g] <= bus_wdata;
    end
  end

  ser_tx_hold #(.BYTE_W(BYTE_W)) u_tx (
    .clk(clk), .rst_n(rst_n), .load(dout_go), .load_byte(bus_wdata[BYTE_W-1:0]),
    .tx_ready(tx_ready), .tx_valid(tx_valid), .tx_data(tx_data), .busy(tx_busy)
  );

  ser_rx_capture #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .allow(ctrl_q[2][0] || !raw_q[I_RX]),
    .rx_valid(rx_valid), .rx_data(rx_data), .consume(bus_rd && sel == S_STATCLR),
    .rx_ready(rx_ready), .take(rx_take), .byte_q(rx_byte), .dav_q(rx_dav)
  );

  ser_irq_ctrl #(.DATA_W(DATA_W), .TX_BIT(I_TX), .RX_BIT(I_RX)) u_irq (
    .clk(clk), .rst_n(rst_n), .mask_we(wr_go && sel == S_MASK),
    .ack_we(wr_go && sel_ack), .wdata(bus_wdata), .tx_set(dout_go),
    .rx_set(rx_take), .raw_q(raw_q), .mask_q(mask_q), .masked(masked),
    .tx_pend_q(tx_pend), .irq(irq)
  );

  always_comb begin
    stat = '0;
    stat[BYTE_W-1:0] = rx_byte;
    stat[B_DAV]      = rx_dav;
    stat[B_IDLE]     = !tx_valid;
    stat[B_RDY]      = !tx_valid;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        S_TXCTL:           bus_rdata = ctrl_q[0];
        S_DMAEN:           bus_rdata = ctrl_q[1];
        S_RXCTL:           bus_rdata = ctrl_q[2];
        S_STATCLR, S_STAT: bus_rdata = stat;
        S_MASK:            bus_rdata = mask_q;
        S_RAW:             bus_rdata = raw_q;
        S_MASKED:          bus_rdata = masked;
        default:           bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/ser_regfile_chk.sv
module ser_regfile_chk #(
  parameter int DATA_W = 32,
  parameter int BYTE_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              bus_wait,
  input logic              sel_dout,
  input logic              sel_ack,
  input logic              sel_peek,
  input logic [BYTE_W-1:0] wbyte,
  input logic              tx_valid,
  input logic              tx_ready,
  input logic [BYTE_W-1:0] tx_data,
  input logic              rx_valid,
  input logic              rx_ready,
  input logic [BYTE_W-1:0] rx_data,
  input logic              rx_dav,
  input logic [BYTE_W-1:0] rx_byte,
  input logic [DATA_W-1:0] raw_q,
  input logic [DATA_W-1:0] mask_q,
  input logic              tx_pend,
  input logic              irq
);
  p_tx_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && !tx_ready |=> tx_valid && $stable(tx_data));
  p_tx_launch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel_dout && !bus_wait |=> tx_valid && tx_data == $past(wbyte));
  p_stall_held_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wait |-> tx_valid);
  p_tx_raw_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel_dout && !bus_wait |=> raw_q[0] && tx_pend);
  p_rx_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> raw_q[3]);
  p_rx_take_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid && rx_ready |=> rx_dav && rx_byte == $past(rx_data) && raw_q[3]);
  p_peek_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd && sel_peek && !(rx_valid && rx_ready) |=> $stable(rx_dav));
  p_ack_pend_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wr && sel_ack && wbyte[0] && tx_pend |=> raw_q[0] && !tx_pend);
  p_irq_src_r11: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (raw_q != '0) && (mask_q != '0));
endmodule

bind ser_regfile ser_regfile_chk #(.DATA_W(DATA_W), .BYTE_W(BYTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wait(bus_wait),
  .sel_dout(sel_dout), .sel_ack(sel_ack), .sel_peek(sel_peek),
  .wbyte(bus_wdata[BYTE_W-1:0]), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data),
  .rx_dav(rx_dav), .rx_byte(rx_byte), .raw_q(raw_q), .mask_q(mask_q),
  .tx_pend(tx_pend), .irq(irq)
);

// File: tb/tb_ser_regfile.sv
module tb_ser_regfile;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        bus_wait, tx_valid, rx_ready, irq;
  logic        tx_ready = 1'b0, rx_valid = 1'b0;
  logic [7:0]  tx_data, rx_data = '0;

  int n_chk = 0, n_bad = 0, n_tx = 0;
  logic [7:0] tx_log [16];
  logic [31:0] rd;
  logic acc;

  always #10 clk = ~clk;

  ser_regfile dut (.*);

  always begin
    @(negedge clk); #3;
    if (rst_n && tx_valid && tx_ready && n_tx < 16) begin
      tx_log[n_tx] = tx_data; n_tx++;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    logic w;
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    forever begin
      #1 w = bus_wait;
      @(posedge clk);
      if (!w) break;
      @(negedge clk);
    end
    #1 bus_wr = 1'b0;
  endtask

  task automatic rdr(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic rx_send(input logic [7:0] b, output logic ok);
    @(negedge clk); rx_valid = 1'b1; rx_data = b;
    #1 ok = rx_ready;
    @(posedge clk); #1 rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] st(input logic [7:0] b, input logic dav, input logic busy);
    return {7'd0, !busy, 1'b0, !busy, 5'd0, dav, 8'd0, b};
  endfunction

  task automatic clear_raw();
    wr(12'h030, 32'h9); wr(12'h030, 32'h9);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 / R12: sweep every word offset at reset
    for (int a = 0; a <= 'h3C; a += 4) begin
      rdr(a[11:0], rd);
      chk($sformatf("R1 R12 reset read @%0h", a), rd,
          (a == 'h20 || a == 'h24) ? 32'h0140_0000 : 32'h0);
    end
    chk("R1 irq", {31'd0, irq}, 0);
    chk("R1 tx_valid", {31'd0, tx_valid}, 0);
    // R2: control registers read back
    foreach (tx_log[i]) tx_log[i] = '0;
    for (int r = 0; r < 4; r++) begin
      logic [11:0] a;
      a = (r == 3) ? 12'h02C : 12'(r * 4);
      for (int p = 0; p < 4; p++) begin
        logic [31:0] v;
        v = (p == 0) ? 32'hFFFF_FFFF : (p == 1) ? 32'hA5C3_0F96 : (p == 2) ? 32'h1 << (r * 7 + 3) : 32'h0;
        wr(a, v); rdr(a, rd);
        chk($sformatf("R2 readback @%0h", a), rd, v);
      end
    end
    // R12: writes to read-only / unmapped offsets
    wr(12'h020, '1); wr(12'h024, '1); wr(12'h034, '1); wr(12'h038, '1);
    wr(12'h03C, '1); wr(12'h010, '1); wr(12'h030 + 12'h100, '1);
    rdr(12'h024, rd); chk("R12 status untouched", rd, 32'h0140_0000);
    rdr(12'h034, rd); chk("R12 raw untouched", rd, 0);
    rdr(12'h02C, rd); chk("R12 mask untouched", rd, 0);
    rdr(12'h01C, rd); chk("R12 data-out reads zero", rd, 0);
    // R3 / R5: launch a byte with the sink stalled
    wr(12'h01C, 32'h1234_56C3);
    chk("R3 tx_valid", {31'd0, tx_valid}, 1);
    chk("R3 tx_data", {24'd0, tx_data}, 32'hC3);
    rdr(12'h034, rd); chk("R5 raw bit0", rd, 1);
    rdr(12'h024, rd); chk("R3 status busy", rd, st(8'h0, 0, 1));
    repeat (3) @(negedge clk);
    #1 chk("R3 held", {23'd0, tx_valid, tx_data}, {23'd0, 1'b1, 8'hC3});
    // R4: second write stalls until the sink accepts
    fork
      wr(12'h01C, 32'h7E);
      begin
        repeat (2) @(negedge clk);
        #2 chk("R4 bus_wait high", {31'd0, bus_wait}, 1);
        @(negedge clk); tx_ready = 1'b1;
      end
    join
    repeat (3) @(negedge clk);
    chk("R4 byte count", n_tx, 2);
    chk("R4 order", {tx_log[0], tx_log[1]}, {8'hC3, 8'h7E});
    rdr(12'h024, rd); chk("R3 status idle again", rd, st(8'h0, 0, 0));
    // R10 / R9: acknowledge with transmit pending
    wr(12'h030, 32'h1);
    rdr(12'h034, rd); chk("R10 raw0 kept", rd, 1);
    wr(12'h030, 32'h1);
    rdr(12'h034, rd); chk("R10 raw0 cleared", rd, 0);
    rdr(12'h030, rd); chk("R9 ack reads zero", rd, 0);
    // R6 / R7 / R8: receive path
    rx_send(8'h41, acc); chk("R6 accept idle", {31'd0, acc}, 1);
    rdr(12'h024, rd); chk("R7 status", rd, st(8'h41, 1, 0));
    rdr(12'h034, rd); chk("R7 raw bit3", rd, 8);
    rx_send(8'h42, acc); chk("R6 blocked", {31'd0, acc}, 0);
    rdr(12'h024, rd); chk("R6 status unchanged", rd, st(8'h41, 1, 0));
    rdr(12'h024, rd); chk("R8 peek keeps dav", rd, st(8'h41, 1, 0));
    rdr(12'h020, rd); chk("R8 consume read", rd, st(8'h41, 1, 0));
    rdr(12'h024, rd); chk("R8 dav cleared", rd, st(8'h41, 0, 0));
    wr(12'h008, 32'h1);
    rx_send(8'h55, acc); chk("R6 rx ctrl override", {31'd0, acc}, 1);
    rdr(12'h024, rd); chk("R7 overwrite", rd, st(8'h55, 1, 0));
    fork
      rdr(12'h020, rd);
      rx_send(8'h66, acc);
    join
    chk("R8 same-cycle read", rd, st(8'h55, 1, 0));
    rdr(12'h024, rd); chk("R8 take beats clear", rd, st(8'h66, 1, 0));
    // R11: every source combination against every low mask nibble
    for (int rc = 0; rc < 4; rc++) begin
      logic [31:0] rexp;
      clear_raw();
      if (rc[0]) wr(12'h01C, 32'h30 + rc);
      if (rc[1]) rx_send(8'(rc), acc);
      rexp = {28'd0, rc[1], 2'b00, rc[0]};
      rdr(12'h034, rd); chk("R11 raw setup", rd, rexp);
      for (int m = 0; m < 16; m++) begin
        wr(12'h02C, 32'(m));
        rdr(12'h038, rd); chk($sformatf("R11 masked r%0d m%0d", rc, m), rd, rexp & 32'(m));
        chk("R11 irq", {31'd0, irq}, {31'd0, (rexp & 32'(m)) != 0});
      end
    end
    wr(12'h02C, 32'h0);
    // R9: every low acknowledge nibble with both sources raised, nothing pending
    for (int v = 0; v < 16; v++) begin
      clear_raw();
      wr(12'h01C, 32'hA0); wr(12'h030, 32'h1);
      rx_send(8'(v), acc);
      wr(12'h030, 32'(v));
      rdr(12'h034, rd); chk($sformatf("R9 ack %0d", v), rd, 32'h9 & ~32'(v));
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule